// File: doc/BRIEF.md
# I2C Slave Transmitter with Event Status Codes

This block is the slave-transmit half of a two-wire serial interface. It watches SCL and SDA through synchronisers and detects START and STOP conditions. After a START it collects a 7-bit address and a direction bit. When the address equals the host-programmed own address, the direction bit is 1 (read) and acknowledging is enabled, it pulls SDA low in the ninth clock. It then raises an interrupt flag and holds SCL low until the host has prepared a byte. Each byte is shifted out MSB first, and the master's acknowledge bit selects the next status code.

The host sees one byte-wide status code for every bus event. It clears the flag to let the transfer go on, and it uses the acknowledge-enable input to mark the final byte or to detach the block from the bus. A START or STOP in the middle of a frame is a bus error, and a fixed host sequence recovers from it. The open-drain lines are modelled as level inputs plus pull-low enables.

States:
- `ST_IDLE`: not addressed.
- `ST_ADDR`: collecting the address frame.
- `ST_ADDR_ACK`: driving the address ACK.
- `ST_HOLD`: flag set, waiting for the host.
- `ST_TX`: shifting a byte.
- `ST_WAIT_ACK`: sampling the master's acknowledge.
- `ST_DONE`: the final status is pending.
- `ST_BUS_ERR`: an illegal START or STOP was seen.

Transitions:
- IDLE→ADDR on START.
- ADDR→ADDR_ACK on a match at the falling SCL edge after eight bits; ADDR→IDLE on a mismatch.
- ADDR_ACK→HOLD at the end of the ACK clock.
- HOLD→TX on a flag clear.
- TX→WAIT_ACK after eight bits.
- WAIT_ACK→HOLD on ACK of a non-final byte; WAIT_ACK→DONE otherwise.
- DONE→IDLE on a flag clear.
- Any frame state→BUS_ERR on START or STOP.
- BUS_ERR→IDLE once the stop bit is set and the flag is cleared.

Top module: `i2c_slave_tx`

## Requirements
- R1: After reset the flag is 0, status reads F8h, the stop bit is 0, and both pull-low enables are 0.
- R2: The address byte is received MSB first, address in bits 7:1 and direction in bit 0. Only own address with bit 0 = 1 and ack_en = 1 gives an ACK (SDA low in clock 9) followed by flag set with status A8h. Any other address, or a write bit, gives no ACK and no flag.
- R3: When the flag is cleared in ST_HOLD, tx_data is loaded and sent MSB first, with SDA changing only while SCL is low.
- R4: With ack_en = 1 at load, a master ACK (SDA low) yields status B8h and the next byte follows. A master NACK yields C0h, and after the flag clear the block is not addressed.
- R5: With ack_en = 0 at load the byte is the last. ACK yields C8h and NACK yields C0h. After the flag clear, SDA stays released, so a master that keeps clocking reads FFh.
- R6: While ack_en = 0 the own address is not acknowledged. Setting ack_en = 1 again restores address recognition.
- R7: scl_oe is 1 whenever the flag is set, and it returns to 0 when the host clears the flag.
- R8: status reads F8h whenever the flag is 0.
- R9: A START or STOP during an address bit, data bit or acknowledge bit sets the flag with status 00h and releases SDA.
- R10: stop_req sets stop_bit only while in bus error. A flag clear with stop_bit set returns the block to idle and clears stop_bit, with no STOP driven (sda_oe stays 0) and SCL released. stop_req at any other time has no effect.
- R11: A STOP while the block is not addressed is not an error: the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | ADDR_W | Own slave address |
| ack_en | input | 1 | Acknowledge enable: answer address, non-final byte |
| tx_data | input | DATA_W | Next byte to send, sampled at flag clear |
| irq_clr | input | 1 | One-cycle pulse clearing the interrupt flag |
| stop_req | input | 1 | One-cycle pulse setting the stop bit |
| irq | output | 1 | Interrupt flag |
| stop_bit | output | 1 | Stop bit, cleared by the block on recovery |
| status | output | 8 | Event status code |

## Verification
A table of read transfers varies the address, the direction bit, ack_en at address time and at byte load, the master's acknowledge and the data pattern. Together these separate an acknowledged address from a rejected one, a detached block from a mismatch, and C0h from C8h. Directed runs cover a two-byte acknowledged read, which tells B8h apart from the final codes, and clocking past C8h, which must return all ones. They also place a STOP inside an address and a START inside a data byte, each followed by recovery and a fresh transfer. A stop request outside the error state completes the set.

// File: rtl/i2c_stx_pkg.sv
package i2c_stx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_HOLD,
        ST_TX, ST_WAIT_ACK, ST_DONE, ST_BUS_ERR
    } stx_state_e;

    localparam logic [7:0] CODE_ADDR_READ  = 8'hA8;
    localparam logic [7:0] CODE_ACKED      = 8'hB8;
    localparam logic [7:0] CODE_NACKED     = 8'hC0;
    localparam logic [7:0] CODE_LAST_ACKED = 8'hC8;
    localparam logic [7:0] CODE_NONE       = 8'hF8;
    localparam logic [7:0] CODE_BUS_ERR    = 8'h00;
endpackage

// File: rtl/i2c_stx_sync.sv
module i2c_stx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_cur   = scl_pipe[STAGES-1];
    assign sda_lvl   = sda_pipe[STAGES-1];
    // SDA edges while SCL stays high mark START (falling) and STOP (rising)
    assign start_det = scl_cur & scl_prev & sda_prev & ~sda_lvl;
    assign stop_det  = scl_cur & scl_prev & ~sda_prev & sda_lvl;
    assign scl_rise  = scl_cur & ~scl_prev;
    assign scl_fall  = ~scl_cur & scl_prev;
endmodule

// File: rtl/i2c_stx_fsm.sv
module i2c_stx_fsm
    import i2c_stx_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ack_en,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              irq_clr,
    input  logic              stop_req,
    output logic              scl_hold,
    output logic              sda_low,
    output logic              irq,
    output logic [7:0]        code,
    output logic              stop_bit
);
    localparam int FRAME_W = ADDR_W + 1;
    localparam int MAX_W   = (DATA_W > FRAME_W) ? DATA_W : FRAME_W;
    localparam int CNT_W   = $clog2(MAX_W + 1);

    stx_state_e          state, nxt;
    logic [FRAME_W-1:0]  rx_sh;
    logic [DATA_W-1:0]   tx_sh;
    logic [CNT_W-1:0]    bit_cnt;
    logic                last_q, ack_q, irq_q, scl_hold_q, sda_low_q, stop_q;
    logic [7:0]          code_q;
    logic                in_frame, bus_err, addr_hit;

    assign in_frame = (state == ST_ADDR) || (state == ST_ADDR_ACK) ||
                      (state == ST_TX)   || (state == ST_WAIT_ACK);
    assign bus_err  = in_frame && (start_det || stop_det);
    assign addr_hit = (rx_sh == {own_addr, 1'b1}) && ack_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (start_det) nxt = ST_ADDR;
            ST_ADDR:
                if (bus_err) nxt = ST_BUS_ERR;
                else if (scl_fall && bit_cnt == CNT_W'(FRAME_W))
                    nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
            ST_ADDR_ACK:
                if (bus_err)       nxt = ST_BUS_ERR;
                else if (scl_fall) nxt = ST_HOLD;
            ST_HOLD:     if (irq_clr) nxt = ST_TX;
            ST_TX:
                if (bus_err) nxt = ST_BUS_ERR;
                else if (scl_fall && bit_cnt == CNT_W'(DATA_W - 1))
                    nxt = ST_WAIT_ACK;
            ST_WAIT_ACK:
                if (bus_err)       nxt = ST_BUS_ERR;
                else if (scl_fall) nxt = (!ack_q && !last_q) ? ST_HOLD : ST_DONE;
            ST_DONE:     if (irq_clr) nxt = ST_IDLE;
            ST_BUS_ERR:  if (stop_q && (irq_clr || !irq_q)) nxt = ST_IDLE;
        endcase
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh      <= '0;
            tx_sh      <= '0;
            bit_cnt    <= '0;
            last_q     <= 1'b0;
            ack_q      <= 1'b1;
            irq_q      <= 1'b0;
            scl_hold_q <= 1'b0;
            sda_low_q  <= 1'b0;
            stop_q     <= 1'b0;
            code_q     <= CODE_NONE;
        end else begin
            if (irq_clr) begin
                irq_q      <= 1'b0;
                scl_hold_q <= 1'b0;
            end
            if (stop_req && state == ST_BUS_ERR) stop_q <= 1'b1;
            if (nxt == ST_BUS_ERR && state != ST_BUS_ERR) begin
                irq_q      <= 1'b1;
                scl_hold_q <= 1'b1;
                sda_low_q  <= 1'b0;
                code_q     <= CODE_BUS_ERR;
            end else begin
                unique case (state)
                    ST_IDLE: begin
                        sda_low_q <= 1'b0;
                        if (start_det) bit_cnt <= '0;
                    end
                    ST_ADDR: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[FRAME_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (nxt == ST_ADDR_ACK) sda_low_q <= 1'b1;
                    end
                    ST_ADDR_ACK:
                        if (nxt == ST_HOLD) begin
                            sda_low_q  <= 1'b0;
                            irq_q      <= 1'b1;
                            scl_hold_q <= 1'b1;
                            code_q     <= CODE_ADDR_READ;
                        end
                    ST_HOLD:
                        if (nxt == ST_TX) begin
                            tx_sh     <= tx_data;
                            sda_low_q <= ~tx_data[DATA_W-1];
                            last_q    <= ~ack_en;
                            bit_cnt   <= '0;
                        end
                    ST_TX:
                        if (scl_fall) begin
                            if (bit_cnt == CNT_W'(DATA_W - 1)) begin
                                sda_low_q <= 1'b0;
                            end else begin
                                tx_sh     <= tx_sh << 1;
                                sda_low_q <= ~tx_sh[DATA_W-2];
                                bit_cnt   <= bit_cnt + 1'b1;
                            end
                        end
                    ST_WAIT_ACK: begin
                        if (scl_rise) ack_q <= sda_lvl;
                        if (scl_fall) begin
                            irq_q      <= 1'b1;
                            scl_hold_q <= 1'b1;
                            code_q     <= ack_q  ? CODE_NACKED :
                                          last_q ? CODE_LAST_ACKED : CODE_ACKED;
                        end
                    end
                    ST_DONE: sda_low_q <= 1'b0;
                    ST_BUS_ERR: begin
                        sda_low_q <= 1'b0;
                        if (nxt == ST_IDLE) begin
                            stop_q     <= 1'b0;
                            irq_q      <= 1'b0;
                            scl_hold_q <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    assign scl_hold = scl_hold_q;
    assign sda_low  = sda_low_q;
    assign irq      = irq_q;
    assign code     = code_q;
    assign stop_bit = stop_q;

    a_r7_hold_while_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> scl_hold_q);
    a_r2_a8_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_q) && code_q == CODE_ADDR_READ) |-> $past(state) == ST_ADDR_ACK);
    a_r9_err_frees_sda: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUS_ERR) |-> !sda_low_q);
    a_r10_stop_only_in_err: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_q) |-> state == ST_BUS_ERR);
    a_r10_stop_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_q) |-> (state == ST_IDLE && !irq_q));
    a_r5_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!sda_low_q && !scl_hold_q));
endmodule

// File: rtl/i2c_slave_tx.sv
module i2c_slave_tx
    import i2c_stx_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ack_en,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              irq_clr,
    input  logic              stop_req,
    output logic              irq,
    output logic              stop_bit,
    output logic [7:0]        status
);
    logic       sda_lvl, start_det, stop_det, scl_rise, scl_fall;
    logic [7:0] code;

    i2c_stx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det),
        .scl_rise(scl_rise), .scl_fall(scl_fall)
    );

    i2c_stx_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
        .own_addr(own_addr), .ack_en(ack_en), .tx_data(tx_data),
        .irq_clr(irq_clr), .stop_req(stop_req), .scl_hold(scl_oe),
        .sda_low(sda_oe), .irq(irq), .code(code), .stop_bit(stop_bit)
    );

    assign status = irq ? code : CODE_NONE;
endmodule

// File: tb/i2c_slave_tx_bench.sv
module i2c_slave_tx_bench;
    localparam int         HALF = 8;
    localparam logic [6:0] OWN  = 7'h5A;
    // {addr[27:21], rw[20], aa_addr[19], aa_load[18], mack[17], data[16:9], acked[8], code[7:0]}
    localparam logic [27:0] VEC [7] = '{
        {7'h5A, 1'b1, 1'b1, 1'b1, 1'b0, 8'hA5, 1'b1, 8'hC0},
        {7'h5A, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'hF8},
        {7'h2C, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'hF8},
        {7'h5A, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'hF8},
        {7'h5A, 1'b1, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b1, 8'hC8},
        {7'h5A, 1'b1, 1'b1, 1'b0, 1'b0, 8'hC3, 1'b1, 8'hC0},
        {7'h5A, 1'b1, 1'b1, 1'b1, 1'b0, 8'h01, 1'b1, 8'hC0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic ack_en = 1'b1, irq_clr = 1'b0, stop_req = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic scl_oe, sda_oe, irq, stop_bit;
    logic [7:0] status;
    logic scl_line, sda_line;
    int   checks = 0, errors = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;
    assign scl_line = !(m_scl_low || scl_oe);
    assign sda_line = !(m_sda_low || sda_oe);

    i2c_slave_tx u_i2c_slave_tx (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .ack_en(ack_en),
        .tx_data(tx_data), .irq_clr(irq_clr), .stop_req(stop_req),
        .irq(irq), .stop_bit(stop_bit), .status(status)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic scl_up();
        m_scl_low = 1'b0;
        while (!scl_line) tick(1);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; m_scl_low = 1'b0; tick(HALF);
        m_sda_low = 1'b1; tick(HALF);
        m_scl_low = 1'b1; tick(HALF);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; tick(HALF);
        scl_up(); tick(HALF);
        m_sda_low = 1'b0; tick(HALF);
    endtask

    task automatic send_bit(input logic b);
        m_sda_low = !b; tick(HALF);
        scl_up(); tick(HALF);
        m_scl_low = 1'b1;
    endtask

    task automatic read_bit(output logic b);
        m_sda_low = 1'b0; tick(HALF);
        scl_up(); tick(HALF / 2);
        b = sda_line; tick(HALF / 2);
        m_scl_low = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic read_byte(output logic [7:0] v);
        for (int i = 7; i >= 0; i--) read_bit(v[i]);
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 500) begin tick(1); n++; end
        chk(req, {7'b0, irq}, 8'h01);
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(2);
    endtask

    task automatic addr_phase(input logic [7:0] abyte, output logic ackbit);
        bus_start();
        send_byte(abyte);
        read_bit(ackbit);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic       b;
        logic [7:0] v;
        tick(4);
        // R1 reset state, R8 idle status
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R8 status", status, 8'hF8);
        chk("R1 lines", {6'b0, scl_oe, sda_oe}, 8'h00);
        chk("R1 stop_bit", {7'b0, stop_bit}, 8'h00);
        rst_n = 1'b1; tick(4);
        chk("R1 after release", status, 8'hF8);

        // table of read transfers (R2, R3, R4, R5, R6, R11)
        for (int k = 0; k < 7; k++) begin
            ack_en = VEC[k][19];
            addr_phase({VEC[k][27:21], VEC[k][20]}, b);
            chk($sformatf("R2/R6 addr ack vec%0d", k), {7'b0, !b}, {7'b0, VEC[k][8]});
            if (VEC[k][8]) begin
                wait_irq("R2 irq");
                chk("R2 status A8", status, 8'hA8);
                chk("R7 hold", {7'b0, scl_oe}, 8'h01);
                ack_en = VEC[k][18]; tx_data = VEC[k][16:9];
                pulse_clr();
                read_byte(v);
                chk($sformatf("R3 data vec%0d", k), v, VEC[k][16:9]);
                send_bit(!VEC[k][17]);
                wait_irq("R4/R5 irq");
                chk($sformatf("R4/R5 code vec%0d", k), status, VEC[k][7:0]);
                pulse_clr();
                chk("R7 release", {7'b0, scl_oe}, 8'h00);
                ack_en = 1'b1;
            end
            bus_stop(); tick(4);
            chk("R11 stop idle", {7'b0, irq}, 8'h00);
            chk("R8 F8", status, 8'hF8);
        end

        // R4 two-byte read with ACK then NACK
        ack_en = 1'b1;
        addr_phase({OWN, 1'b1}, b);
        wait_irq("R2 irq");
        tx_data = 8'h96; pulse_clr();
        read_byte(v); chk("R3 byte1", v, 8'h96);
        send_bit(1'b0);
        wait_irq("R4 irq");
        chk("R4 B8", status, 8'hB8);
        tick(20);
        chk("R7 stretched", {6'b0, scl_oe, scl_line}, 8'h02);
        tx_data = 8'h69; pulse_clr();
        read_byte(v); chk("R4 byte2", v, 8'h69);
        send_bit(1'b1);
        wait_irq("R4 irq2");
        chk("R4 C0", status, 8'hC0);
        pulse_clr(); bus_stop(); tick(4);

        // R5 last byte, master keeps clocking: reads all ones
        addr_phase({OWN, 1'b1}, b);
        wait_irq("R2 irq");
        ack_en = 1'b0; tx_data = 8'h00; pulse_clr();
        read_byte(v); chk("R5 last data", v, 8'h00);
        send_bit(1'b0);
        wait_irq("R5 irq");
        chk("R5 C8", status, 8'hC8);
        pulse_clr();
        read_byte(v); chk("R5 ones", v, 8'hFF);
        chk("R5 no irq", {7'b0, irq}, 8'h00);
        send_bit(1'b1); bus_stop(); tick(4);
        ack_en = 1'b1;

        // R10 stop request outside error ignored
        stop_req = 1'b1; tick(1); stop_req = 1'b0; tick(3);
        chk("R10 ignored", {7'b0, stop_bit}, 8'h00);

        // R9 STOP inside address byte, then R10 recovery
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        wait_irq("R9 irq");
        chk("R9 code 00", status, 8'h00);
        chk("R9 sda released", {7'b0, sda_oe}, 8'h00);
        stop_req = 1'b1; tick(1); stop_req = 1'b0; tick(2);
        chk("R10 stop set", {7'b0, stop_bit}, 8'h01);
        pulse_clr(); tick(2);
        chk("R10 stop cleared", {7'b0, stop_bit}, 8'h00);
        chk("R10 released", {6'b0, scl_oe, sda_oe}, 8'h00);
        chk("R10 F8", status, 8'hF8);
        addr_phase({OWN, 1'b1}, b);
        chk("R10 readdressed", {7'b0, b}, 8'h00);
        wait_irq("R2 irq");
        chk("R10 A8", status, 8'hA8);

        // R9 START inside data byte
        tx_data = 8'hFF; pulse_clr();
        read_bit(b); read_bit(b); read_bit(b);
        m_sda_low = 1'b0; tick(HALF);
        scl_up(); tick(HALF);
        m_sda_low = 1'b1; tick(2);
        wait_irq("R9 irq2");
        chk("R9 code 00 data", status, 8'h00);
        m_scl_low = 1'b1; tick(HALF);
        m_sda_low = 1'b0;
        stop_req = 1'b1; irq_clr = 1'b1; tick(1);
        stop_req = 1'b0; irq_clr = 1'b0; tick(1);
        irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(3);
        chk("R10 recover2", {6'b0, irq, stop_bit}, 8'h00);
        chk("R10 sda2", {7'b0, sda_oe}, 8'h00);
        m_scl_low = 1'b0; tick(HALF);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule